// File: doc/BRIEF.md
# SPI Flash Bank Address Extension

This block forms the memory-array address inside the command front end of a serial NOR flash. Many SPI commands carry only a 24-bit address, which reaches 16 MB. The block holds a one-byte bank register. Its two low bits supply array address bits 24 and 25, so legacy three-byte commands can reach the upper part of a 256 or 512 Mbit array without any change to the command.

The block decodes the opcodes that touch the bank register. One opcode writes the register directly and another presents it for reading. A legacy prefix opcode arms a one-shot redirect: when the next command is the ordinary register-write opcode, its data byte goes to the bank register instead of status register 1. The top bit of the register switches the standard addressed commands to four address bytes. Dedicated four-byte opcodes always take four bytes and never use the bank bits.

For each command, the block tells the serial shifter how many address bytes to collect. It then returns the masked 26-bit array address. A parameter sets the density, and that setting decides which bank bits exist.

Top module: `spi_bank_addr_ext`

## Requirements
- R1: After reset the bank register reads 00h, the redirect is disarmed, `addr_len` is 0 and `sr1_wr` is 0. An asynchronous reset in mid-operation returns the register to 00h.
- R2: Opcode 17h followed by a data byte stores that byte in the bank register. `bank_rd` shows the register, which opcode 16h returns. Bits 6..2 always read 0. The register changes only on the clock after an accepted data byte.
- R3: With DENSITY_MBIT = 128, bank bits 1 and 0 read 0. With 256, only bit 1 reads 0. With 512, both bits are writable. Array address bits at or above the density's address width are always 0.
- R4: When bank bit 7 is 0, a standard addressed opcode gives `addr_len` = 3. The array address is then {bank[1], bank[0], addr_in[23:0]}, masked as in R3. Standard opcodes include 03h, 0Bh, 02h, D8h and 20h.
- R5: When bank bit 7 is 1, a standard addressed opcode gives `addr_len` = 4. The array address is then addr_in[25:0], masked as in R3, and the bank bits are not used.
- R6: A dedicated four-byte opcode gives `addr_len` = 4 and an array address of addr_in[25:0], masked, whatever the value of the bank register. These opcodes include 13h, 0Ch, 12h, 21h and DCh.
- R7: After opcode B9h, a following command with opcode 01h writes its data byte to the bank register, and `sr1_wr` stays 0. This works across a chip-select boundary, and the redirect is then consumed.
- R8: Opcode 01h without an armed redirect produces a one-cycle `sr1_wr` pulse on the clock after its data byte, and it leaves the bank register unchanged.
- R9: The armed redirect is cancelled by any opcode other than 01h and B9h. It is also cancelled by a chip-select frame that ends without an opcode. After a cancel, opcode 01h acts as in R8.
- R10: An opcode without an address, such as 05h, 16h or B9h, gives `addr_len` = 0. `addr_len` only ever takes the values 0, 3 or 4. It is valid from the clock after `op_valid` until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| op_valid | input | 1 | One-cycle strobe: opcode byte complete |
| op_code | input | 8 | Opcode byte |
| data_valid | input | 1 | One-cycle strobe: register data byte complete |
| data_byte | input | 8 | Register data byte |
| addr_valid | input | 1 | One-cycle strobe: address bytes complete |
| addr_in | input | 26 | Low 26 bits of the shifted address |
| addr_len | output | 3 | Address bytes the shifter must collect (0, 3 or 4) |
| array_addr | output | 26 | Formed array address, registered on addr_valid |
| bank_rd | output | 8 | Bank register contents (opcode 16h read data) |
| sr1_wr | output | 1 | One-cycle pulse: data byte goes to status register 1 |

## Verification
The bench targets the redirect's life cycle. It checks consumption by 01h in the next frame, cancellation by an unrelated opcode, and cancellation by an empty frame. A design that lets the redirect linger would send a later status write into the bank register, and one that clears it at every chip-select rise would never redirect at all. It drives an address with all bits set through a 512 Mbit and a 128 Mbit instance side by side, so that missing density masking shows up as stray upper bits. It also checks that dedicated four-byte opcodes ignore nonzero bank bits, and that setting bit 7 stops the bank bits from being merged; a design that merged them anyway would alias the upper array.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;

  localparam logic [7:0] OP_BANK_RD = 8'h16;
  localparam logic [7:0] OP_BANK_WR = 8'h17;
  localparam logic [7:0] OP_PREFIX  = 8'hB9;
  localparam logic [7:0] OP_REG_WR  = 8'h01;

  typedef enum logic [1:0] {
    WK_NONE,
    WK_BANK,
    WK_STAT
  } wr_kind_e;

  typedef enum logic [1:0] {
    AC_NONE,
    AC_STD,
    AC_WIDE
  } addr_cls_e;

  // Address class of an opcode: standard 3-or-4 byte, always 4 byte, or none.
  function automatic addr_cls_e classify(input logic [7:0] op);
    addr_cls_e c;
    case (op)
      8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB,
      8'h02, 8'h32, 8'hD8, 8'h20, 8'h0D, 8'hBD, 8'hED: c = AC_STD;
      8'h13, 8'h0C, 8'h3C, 8'h6C, 8'hBC, 8'hEC,
      8'h0E, 8'hBE, 8'hEE, 8'h12, 8'h34, 8'h21, 8'hDC: c = AC_WIDE;
      default: c = AC_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/spi_bank_decode.sv
module spi_bank_decode
  import spi_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n,
  input  logic      op_valid,
  input  logic [7:0] op_code,
  input  logic      data_valid,
  output addr_cls_e acls,
  output logic      bank_we,
  output logic      stat_pulse
);

  wr_kind_e  kind_q, kind_d;
  addr_cls_e acls_q, acls_d;
  logic      arm_q, arm_d;
  logic      fop_q, fop_d;
  logic      cs_q;
  logic      stat_q;
  logic      data_ok;
  logic      stat_we;

  assign data_ok = data_valid && !cs_n && !op_valid;
  assign bank_we = data_ok && (kind_q == WK_BANK);
  assign stat_we = data_ok && (kind_q == WK_STAT);

  always_comb begin
    kind_d = kind_q;
    acls_d = acls_q;
    arm_d  = arm_q;
    fop_d  = fop_q;
    if (cs_n) begin
      kind_d = WK_NONE;
      acls_d = AC_NONE;
      fop_d  = 1'b0;
      // a frame that closes with no opcode drops the redirect
      if (!cs_q && !fop_q) arm_d = 1'b0;
    end else if (op_valid) begin
      fop_d  = 1'b1;
      acls_d = classify(op_code);
      kind_d = WK_NONE;
      if (op_code == OP_PREFIX) begin
        arm_d = 1'b1;
      end else begin
        arm_d = 1'b0;
        if (op_code == OP_BANK_WR || (op_code == OP_REG_WR && arm_q))
          kind_d = WK_BANK;
        else if (op_code == OP_REG_WR)
          kind_d = WK_STAT;
      end
    end else if (data_valid) begin
      kind_d = WK_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= WK_NONE;
      acls_q <= AC_NONE;
      arm_q  <= 1'b0;
      fop_q  <= 1'b0;
      cs_q   <= 1'b1;
      stat_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      acls_q <= acls_d;
      arm_q  <= arm_d;
      fop_q  <= fop_d;
      cs_q   <= cs_n;
      stat_q <= stat_we;
    end
  end

  assign acls       = acls_q;
  assign stat_pulse = stat_q;

endmodule

// File: rtl/spi_bank_reg.sv
module spi_bank_reg #(
  parameter int DENSITY_MBIT = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] bank_q,
  output logic       ext_en,
  output logic [1:0] ba
);

  localparam logic HAS_BA24 = (DENSITY_MBIT >= 256);
  localparam logic HAS_BA25 = (DENSITY_MBIT >= 512);
  localparam logic [7:0] WR_MASK = {1'b1, 5'b00000, HAS_BA25, HAS_BA24};

  logic [7:0] bank_d;

  always_comb begin
    bank_d = bank_q;
    if (we) bank_d = wdata & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= 8'h00;
    else        bank_q <= bank_d;
  end

  assign ext_en = bank_q[7];
  assign ba     = bank_q[1:0];

endmodule

// File: rtl/spi_bank_addr.sv
module spi_bank_addr
  import spi_bank_pkg::*;
#(
  parameter int DENSITY_MBIT = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  addr_cls_e   acls,
  input  logic        ext_en,
  input  logic [1:0]  ba,
  input  logic        addr_valid,
  input  logic [25:0] addr_in,
  output logic [2:0]  addr_len,
  output logic [25:0] array_addr
);

  localparam int ARR_BITS = (DENSITY_MBIT >= 512) ? 26 :
                            (DENSITY_MBIT >= 256) ? 25 : 24;
  localparam logic [25:0] ARR_MASK = 26'((64'd1 << ARR_BITS) - 64'd1);

  logic        wide;
  logic [25:0] raw;
  logic [25:0] addr_q, addr_d;

  assign wide = (acls == AC_WIDE) || (acls == AC_STD && ext_en);

  always_comb begin
    case (acls)
      AC_WIDE: addr_len = 3'd4;
      AC_STD:  addr_len = ext_en ? 3'd4 : 3'd3;
      default: addr_len = 3'd0;
    endcase
  end

  always_comb begin
    raw    = wide ? addr_in : {ba, addr_in[23:0]};
    addr_d = addr_q;
    if (addr_valid) addr_d = raw & ARR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign array_addr = addr_q;

endmodule

// File: rtl/spi_bank_addr_ext.sv
module spi_bank_addr_ext
  import spi_bank_pkg::*;
#(
  parameter int DENSITY_MBIT = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        op_valid,
  input  logic [7:0]  op_code,
  input  logic        data_valid,
  input  logic [7:0]  data_byte,
  input  logic        addr_valid,
  input  logic [25:0] addr_in,
  output logic [2:0]  addr_len,
  output logic [25:0] array_addr,
  output logic [7:0]  bank_rd,
  output logic        sr1_wr
);

  addr_cls_e  acls;
  logic       bank_we;
  logic       ext_en;
  logic [1:0] ba;

  spi_bank_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .data_valid (data_valid),
    .acls       (acls),
    .bank_we    (bank_we),
    .stat_pulse (sr1_wr)
  );

  spi_bank_reg #(.DENSITY_MBIT(DENSITY_MBIT)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (bank_we),
    .wdata  (data_byte),
    .bank_q (bank_rd),
    .ext_en (ext_en),
    .ba     (ba)
  );

  spi_bank_addr #(.DENSITY_MBIT(DENSITY_MBIT)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .acls       (acls),
    .ext_en     (ext_en),
    .ba         (ba),
    .addr_valid (addr_valid),
    .addr_in    (addr_in),
    .addr_len   (addr_len),
    .array_addr (array_addr)
  );

endmodule

// File: rtl/spi_bank_addr_ext_chk.sv
module spi_bank_addr_ext_chk #(
  parameter int DENSITY_MBIT = 512
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        op_valid,
  input logic [7:0]  op_code,
  input logic        data_valid,
  input logic [2:0]  addr_len,
  input logic [25:0] array_addr,
  input logic [7:0]  bank_rd,
  input logic        sr1_wr
);

  localparam logic [1:0] BA_OK = {DENSITY_MBIT >= 512, DENSITY_MBIT >= 256};
  localparam logic [1:0] HI_OK = BA_OK;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd[6:2] == 5'b00000);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |=> $stable(bank_rd));

  assert_density_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_rd[1:0] & ~BA_OK) == 2'b00);

  assert_density_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (array_addr[25:24] & ~HI_OK) == 2'b00);

  assert_std_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !cs_n && op_code == 8'h03) |=> (addr_len == (bank_rd[7] ? 3'd4 : 3'd3)));

  assert_wide_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !cs_n && (op_code == 8'h13 || op_code == 8'hDC)) |=> addr_len == 3'd4);

  assert_no_bank_on_stat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr1_wr |-> $stable(bank_rd));

  assert_stat_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr1_wr |-> $past(data_valid));

  assert_len_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_len == 3'd0 || addr_len == 3'd3 || addr_len == 3'd4);

endmodule

bind spi_bank_addr_ext spi_bank_addr_ext_chk #(.DENSITY_MBIT(DENSITY_MBIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .data_valid (data_valid),
  .addr_len   (addr_len),
  .array_addr (array_addr),
  .bank_rd    (bank_rd),
  .sr1_wr     (sr1_wr)
);

// File: tb/tb_spi_bank_addr_ext.sv
`timescale 1ns/1ps
module tb_spi_bank_addr_ext;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n;
  logic        op_valid;
  logic [7:0]  op_code;
  logic        data_valid;
  logic [7:0]  data_byte;
  logic        addr_valid;
  logic [25:0] addr_in;
  logic [2:0]  addr_len,   addr_len_s;
  logic [25:0] array_addr, array_addr_s;
  logic [7:0]  bank_rd,    bank_rd_s;
  logic        sr1_wr,     sr1_wr_s;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spi_bank_addr_ext #(.DENSITY_MBIT(512)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .op_valid(op_valid), .op_code(op_code),
    .data_valid(data_valid), .data_byte(data_byte), .addr_valid(addr_valid),
    .addr_in(addr_in), .addr_len(addr_len), .array_addr(array_addr),
    .bank_rd(bank_rd), .sr1_wr(sr1_wr));

  spi_bank_addr_ext #(.DENSITY_MBIT(128)) dut_small (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .op_valid(op_valid), .op_code(op_code),
    .data_valid(data_valid), .data_byte(data_byte), .addr_valid(addr_valid),
    .addr_in(addr_in), .addr_len(addr_len_s), .array_addr(array_addr_s),
    .bank_rd(bank_rd_s), .sr1_wr(sr1_wr_s));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] c);
    cs_n = 1'b0;
    op_valid = 1'b1; op_code = c;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic fend();
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic dbyte(input logic [7:0] b, output logic sr);
    data_valid = 1'b1; data_byte = b;
    @(negedge clk);
    sr = sr1_wr;
    data_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic abytes(input logic [25:0] a);
    addr_valid = 1'b1; addr_in = a;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  task automatic bank_write(input logic [7:0] b);
    logic sr;
    op(8'h17); dbyte(b, sr); fend();
  endtask

  task automatic t_reset();
    chk("R1 bank after reset", bank_rd, 8'h00);
    chk("R1 addr_len after reset", addr_len, 3'd0);
    chk("R1 sr1_wr after reset", sr1_wr, 1'b0);
  endtask

  task automatic t_direct_write();
    bank_write(8'hFF);
    chk("R2 write FF, reserved bits masked", bank_rd, 8'h83);
    chk("R3 128 Mbit bank bits read 0", bank_rd_s, 8'h80);
    op(8'h16);
    chk("R2 read opcode shows register", bank_rd, 8'h83);
    chk("R10 read opcode has no address", addr_len, 3'd0);
    fend();
  endtask

  task automatic t_three_byte();
    bank_write(8'h01);
    op(8'h03);
    chk("R4 standard opcode 3 bytes", addr_len, 3'd3);
    abytes(26'h0123456);
    chk("R4 bank merged", array_addr, 26'h1123456);
    fend();
    bank_write(8'h03);
    op(8'h0B);
    abytes(26'h3FFFFFF);
    chk("R4 both bank bits merged", array_addr, 26'h3FFFFFF);
    chk("R3 128 Mbit address masked", array_addr_s, 26'h0FFFFFF);
    fend();
  endtask

  task automatic t_extadd();
    bank_write(8'h81);
    op(8'h03);
    chk("R5 extended mode 4 bytes", addr_len, 3'd4);
    chk("R5 extended mode 4 bytes small", addr_len_s, 3'd4);
    abytes(26'h2ABCDEF);
    chk("R5 bank bits not merged", array_addr, 26'h2ABCDEF);
    chk("R3 small density extended masked", array_addr_s, 26'h0ABCDEF);
    fend();
  endtask

  task automatic t_wide_opcode();
    bank_write(8'h03);
    op(8'h13);
    chk("R6 four-byte opcode length", addr_len, 3'd4);
    abytes(26'h0000010);
    chk("R6 bank ignored", array_addr, 26'h0000010);
    fend();
    op(8'hDC);
    chk("R6 four-byte erase length", addr_len, 3'd4);
    fend();
  endtask

  task automatic t_redirect();
    logic sr;
    bank_write(8'h00);
    op(8'hB9); fend();
    op(8'h01); dbyte(8'h02, sr); fend();
    chk("R7 redirect, no status write", sr, 1'b0);
    chk("R7 redirect writes bank", bank_rd, 8'h02);
    op(8'h01); dbyte(8'h55, sr); fend();
    chk("R8 redirect consumed, status write", sr, 1'b1);
    chk("R8 bank unchanged", bank_rd, 8'h02);
  endtask

  task automatic t_cancel_op();
    logic sr;
    op(8'hB9); fend();
    op(8'h05);
    chk("R10 status read no address", addr_len, 3'd0);
    fend();
    op(8'h01); dbyte(8'h01, sr); fend();
    chk("R9 cancel by opcode, status write", sr, 1'b1);
    chk("R9 cancel by opcode, bank kept", bank_rd, 8'h02);
  endtask

  task automatic t_cancel_empty();
    logic sr;
    op(8'hB9); fend();
    cs_n = 1'b0; @(negedge clk); @(negedge clk); fend();
    op(8'h01); dbyte(8'h01, sr); fend();
    chk("R9 cancel by empty frame, status write", sr, 1'b1);
    chk("R9 cancel by empty frame, bank kept", bank_rd, 8'h02);
  endtask

  task automatic t_reset_mid();
    bank_write(8'h83);
    chk("R2 setup before reset", bank_rd, 8'h83);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears bank", bank_rd, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bank after release", bank_rd, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; op_valid = 1'b0; op_code = 8'h00;
    data_valid = 1'b0; data_byte = 8'h00; addr_valid = 1'b0; addr_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct_write();
    t_three_byte();
    t_extadd();
    t_wide_opcode();
    t_redirect();
    t_cancel_op();
    t_cancel_empty();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule